// File: doc/BRIEF.md
# Frame Buffer Scanout Controller

This block fetches a true-color image from word-addressed memory and turns it into a stream of pixels for a display. Software programs two registers: the frame base address, of which only the upper bits are kept, and a control word that carries a display-enable bit and a 180-degree rotation bit. An external video timing generator pulses `frame_start` at the top of each frame and holds `pix_ready` high while it can take more pixels. The timing generator also produces the sync and porch intervals.

For each visible pixel the block issues one 32-bit read and holds it until the memory grants it. The block has at most one read outstanding, so returned words arrive in request order. Each returned word is split into 8-bit red, green and blue channels and presented with a valid flag. The visible area defaults to 640 by 480 pixels. Rows are laid out with a pitch of 1024 words, and the words past the visible width are never fetched. With rotation on, the walk runs backwards in both directions, so the first pixel shown is the last word of the last visible row.

Top module: `fb_scanout`

## Requirements
- R1: After reset both registers read zero, `mem_req` is low and `pix_valid` is low.
- R2: The register index comes from address bit 2 when `BYTE_ADDR` is 1, and from address bit 0 otherwise. Index 0 is the frame base and index 1 is the control word. Reads are combinational.
- R3: The base register keeps the top `BASE_BITS` bits (default 11) of the written word. It reads back with all lower bits zero.
- R4: Control bit 0 enables the display and control bit 1 selects rotation. Every other control bit reads back as zero.
- R5: Unrotated, the read addresses of one frame run through base + y*ROW_PITCH + x, with x stepping first over `H_VIS` columns and y over `V_VIS` rows. After the last pixel no further read is issued until the next `frame_start`.
- R6: Rotated, the k-th read of a frame goes to base + (V_VIS-1-y)*ROW_PITCH + (H_VIS-1-x), where x = k mod H_VIS and y = k / H_VIS.
- R7: Once raised, `mem_req` and `mem_addr` stay unchanged until the cycle in which `mem_gnt` is high.
- R8: One cycle after `mem_rvalid`, `pix_valid` is high with red = data[23:16], green = data[15:8] and blue = data[7:0]. Data bits 31:24 have no effect on the output.
- R9: While enable is 0, `frame_start` is ignored, no read is issued, and all three colour outputs are zero.
- R10: Clearing enable in the middle of a frame drops the rest of that frame. A request already raised is still held until granted, and no further read follows.
- R11: The base and rotate values are captured at `frame_start`. Register writes during a frame take effect only in the next frame.
- R12: A new read is issued only in a cycle after `pix_ready` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (byte or word offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| frame_start | input | 1 | Start-of-frame pulse from the timing generator |
| pix_ready | input | 1 | Timing generator can accept pixels |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| pix_valid | output | 1 | Pixel output valid |
| pix_red | output | 8 | Red channel |
| pix_green | output | 8 | Green channel |
| pix_blue | output | 8 | Blue channel |

## Verification
Register writes take effect at the next rising edge. Reads are combinational, so the bench samples them a short delay after it sets the address. A read request rises one edge after an enabled cycle with `pix_ready` high, and it falls at the edge where the grant is seen. A pixel appears one edge after `mem_rvalid`. The bench drives inputs and samples all outputs on falling edges. Each grant is therefore compared with its expected address in the same cycle, and each pixel is compared half a cycle after the edge that registered it.

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int ROW_PITCH = 1024,
  parameter int ADDR_W    = 32,
  parameter int BASE_BITS = 11,
  parameter bit BYTE_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frame_start,
  input  logic              pix_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              pix_valid,
  output logic [7:0]        pix_red,
  output logic [7:0]        pix_green,
  output logic [7:0]        pix_blue
);
  localparam int XW    = (H_VIS > 1) ? $clog2(H_VIS) : 1;
  localparam int YW    = (V_VIS > 1) ? $clog2(V_VIS) : 1;
  localparam int LOW_W = 32 - BASE_BITS;
  localparam int ALOW  = ADDR_W - BASE_BITS;

  logic [BASE_BITS-1:0] base_q, fbase_q;
  logic                 en_q, rot_q, frot_q, active_q;
  logic [XW-1:0]        x_q;
  logic [YW-1:0]        y_q;
  logic [23:0]          rgb_q;
  logic                 reg_idx, issue, last_px;
  logic [ADDR_W-1:0]    col_w, row_w, next_addr;

  assign reg_idx   = BYTE_ADDR ? reg_addr[2] : reg_addr[0];
  assign reg_rdata = reg_idx ? {30'd0, rot_q, en_q} : {base_q, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      rot_q  <= 1'b0;
    end else if (reg_we) begin
      if (reg_idx) begin
        en_q  <= reg_wdata[0];
        rot_q <= reg_wdata[1];
      end else begin
        base_q <= reg_wdata[31:LOW_W];
      end
    end
  end

  assign col_w = frot_q ? ADDR_W'(H_VIS - 1) - ADDR_W'(x_q) : ADDR_W'(x_q);
  assign row_w = frot_q ? ADDR_W'(V_VIS - 1) - ADDR_W'(y_q) : ADDR_W'(y_q);
  assign next_addr = {fbase_q, {ALOW{1'b0}}} + row_w * ADDR_W'(ROW_PITCH) + col_w;

  assign last_px = (x_q == XW'(H_VIS - 1)) && (y_q == YW'(V_VIS - 1));
  assign issue   = active_q && en_q && pix_ready && !mem_req && !frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fbase_q  <= '0;
      frot_q   <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
    end else if (frame_start && en_q) begin
      active_q <= 1'b1;
      fbase_q  <= base_q;
      frot_q   <= rot_q;
      x_q      <= '0;
      y_q      <= '0;
    end else if (!en_q) begin
      active_q <= 1'b0;
    end else if (issue) begin
      if (last_px) active_q <= 1'b0;
      if (x_q == XW'(H_VIS - 1)) begin
        x_q <= '0;
        y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (issue) begin
      mem_req  <= 1'b1;
      mem_addr <= next_addr;
    end else if (mem_gnt) begin
      mem_req  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      rgb_q     <= '0;
    end else begin
      pix_valid <= mem_rvalid;
      if (mem_rvalid) rgb_q <= mem_rdata[23:0];
    end
  end

  assign pix_red   = en_q ? rgb_q[23:16] : 8'd0;
  assign pix_green = en_q ? rgb_q[15:8]  : 8'd0;
  assign pix_blue  = en_q ? rgb_q[7:0]   : 8'd0;
endmodule

module fb_scanout_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              pix_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic              mem_rvalid,
  input logic              pix_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !mem_req) |=> !mem_req); // R9
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(pix_ready)); // R12
  AST_PIX_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> pix_valid); // R8
  AST_NO_PIX_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> !pix_valid); // R8
endmodule

bind fb_scanout fb_scanout_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_q), .pix_ready(pix_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
  .mem_rvalid(mem_rvalid), .pix_valid(pix_valid)
);

// File: tb/fb_scanout_bench.sv
module fb_scanout_bench;
  localparam int H = 6, V = 4, PITCH = 16, NPIX = H * V;
  localparam logic [31:0] KEEP = 32'hFFE0_0000;
  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b0, 32'h0000_0000},
    {1'b0, 1'b1, 32'h0020_0000},
    {1'b1, 1'b0, 32'hFFE0_0000},
    {1'b1, 1'b1, 32'h1234_5678}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic frame_start = 1'b0, pix_ready = 1'b0;
  logic mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic pix_valid;
  logic [7:0] pix_red, pix_green, pix_blue;

  int errs = 0, checks = 0, cyc = 0;
  int gidx = 0, ridx = 0;
  logic [31:0] exp_base = '0;
  bit exp_rot = 1'b0, stall = 1'b0, loose = 1'b0, tick = 1'b0;
  bit ret_pend = 1'b0;
  logic [31:0] ret_data = '0;

  always #4 clk = ~clk;

  fb_scanout #(.H_VIS(H), .V_VIS(V), .ROW_PITCH(PITCH), .ADDR_W(32),
               .BASE_BITS(11), .BYTE_ADDR(1'b1)) u_fb_scanout (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_ready(pix_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
    .pix_blue(pix_blue));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int k);
    int x, y;
    x = k % H;
    y = k / H;
    if (exp_rot) begin
      x = H - 1 - x;
      y = V - 1 - y;
    end
    return exp_base + 32'(y * PITCH + x);
  endfunction

  function automatic logic [31:0] mkdata(input logic [31:0] a);
    return {8'hC3, a[23:0] ^ 24'h5A_A55A};
  endfunction

  always @(negedge clk) begin
    if (pix_valid && !loose) begin
      logic [31:0] e;
      e = mkdata(exp_addr(ridx));
      check({pix_red, pix_green, pix_blue} == e[23:0], "R8",
            {8'd0, pix_red, pix_green, pix_blue}, {8'd0, e[23:0]});
    end
    if (pix_valid) ridx++;
    mem_rvalid = ret_pend;
    mem_rdata  = ret_data;
    ret_pend   = 1'b0;
    tick       = ~tick;
    mem_gnt    = mem_req && (!stall || tick);
    if (mem_gnt) begin
      if (!loose)
        check(mem_addr == exp_addr(gidx), exp_rot ? "R6" : "R5", mem_addr, exp_addr(gidx));
      gidx++;
      ret_pend = 1'b1;
      ret_data = mkdata(mem_addr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_start();
    gidx = 0; ridx = 0;
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic finish_frame();
    for (int i = 0; i < 2000 && ridx < NPIX; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(gidx == NPIX, "R5", 32'(gidx), 32'(NPIX));
    check(!mem_req, "R5", 32'(mem_req), 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(3'd0, d); check(d == 32'd0, "R1", d, 32'd0);
    rd(3'd4, d); check(d == 32'd0, "R1", d, 32'd0);
    check(!mem_req && !pix_valid, "R1", {30'd0, mem_req, pix_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, d); check(d == 32'd0, "R1", d, 32'd0);
    check(!mem_req && !pix_valid, "R1", {30'd0, mem_req, pix_valid}, 32'd0);

    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check(d == 32'hFFE0_0000, "R3", d, 32'hFFE0_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); check(d == 32'd3, "R4", d, 32'd3);
    rd(3'd1, d); check(d == 32'hFFE0_0000, "R2", d, 32'hFFE0_0000);
    wr(3'd4, 32'd0);
    rd(3'd4, d); check(d == 32'd0, "R2", d, 32'd0);

    pix_ready = 1'b1;
    pulse_start();
    repeat (20) @(negedge clk);
    check(gidx == 0 && !mem_req, "R9", 32'(gidx), 32'd0);
    check({pix_red, pix_green, pix_blue} == 24'd0, "R9", {8'd0, pix_red, pix_green, pix_blue}, 32'd0);

    foreach (VEC[i]) begin
      stall    = VEC[i][33];
      exp_rot  = VEC[i][32];
      exp_base = VEC[i][31:0] & KEEP;
      wr(3'd0, VEC[i][31:0]);
      wr(3'd4, {30'd0, VEC[i][32], 1'b1});
      pulse_start();
      finish_frame();
      check(ridx == NPIX, exp_rot ? "R6" : "R5", 32'(ridx), 32'(NPIX));
    end

    stall = 1'b0; exp_rot = 1'b0; exp_base = 32'h0400_0000;
    wr(3'd0, 32'h0400_0000);
    wr(3'd4, 32'd1);
    pix_ready = 1'b0;
    pulse_start();
    repeat (10) @(negedge clk);
    check(gidx == 0 && !mem_req, "R12", 32'(gidx), 32'd0);
    pix_ready = 1'b1;
    for (int i = 0; i < 200 && gidx < 4; i++) @(negedge clk);
    wr(3'd0, 32'h4000_0000);
    wr(3'd4, 32'd3);
    finish_frame();
    check(ridx == NPIX, "R11", 32'(ridx), 32'(NPIX));
    exp_base = 32'h4000_0000; exp_rot = 1'b1;
    pulse_start();
    finish_frame();

    exp_rot = 1'b0; exp_base = 32'h0;
    wr(3'd0, 32'h0);
    wr(3'd4, 32'd1);
    pulse_start();
    for (int i = 0; i < 200 && gidx < 5; i++) @(negedge clk);
    loose = 1'b1;
    wr(3'd4, 32'd0);
    repeat (4) @(negedge clk);
    d = 32'(gidx);
    repeat (20) @(negedge clk);
    check(gidx == int'(d) && !mem_req, "R10", 32'(gidx), d);
    check(gidx < NPIX, "R10", 32'(gidx), 32'(NPIX));
    check({pix_red, pix_green, pix_blue} == 24'd0, "R9", {8'd0, pix_red, pix_green, pix_blue}, 32'd0);
    loose = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule